// File: doc/BRIEF.md
# Byte-Masked Line Buffer Array

This block holds a small set of buffers, each exactly one cache line wide, that sit between a load/store pipeline and a first-level data cache. Each buffer keeps a copy of one cache line together with its location in that cache (line number and way), the physical page number of the line, and three flags: whether the contents were actually brought in from the cache (fetched), whether the copy may still be used (line-valid), and whether anything was written (dirty). A per-byte write mask records exactly which bytes the pipeline has stored, so a writeback hands the cache only the modified bytes. The cache is addressed by the stored line number and way, with no tag check.

A buffer is set up by an allocate command. A normal allocation requests a whole-line fill from the cache. A write-first allocation skips the fill, because every location used is written before it is read. In its contiguous flavour, where the whole line is expected to be overwritten, the block asks the cache for a tag-only allocation. A release command writes back a dirty buffer and frees it. If a contiguous write-first buffer was only partly written, the block first asks that the line be fetched from the level below the cache, so that the masked merge lands on real data. An eviction notice from the cache clears line-valid on the matching buffer.

One sequencer serialises all cache traffic. It has four states. IDLE accepts commands. FILL waits for a fill or tag-only acknowledge. LOWER waits for the lower-level fetch acknowledge. WB waits for the writeback acknowledge. The transitions are as follows. IDLE goes to FILL on a normal or contiguous write-first allocate. IDLE goes to LOWER on the release of a dirty, partly written contiguous write-first buffer that was never fetched. IDLE goes to WB on the release of any other dirty, line-valid buffer. FILL returns to IDLE on fill_ack. LOWER goes to WB on lower_ack. WB returns to IDLE on wb_ack. Any other allocate or release completes inside IDLE.

Top module: `line_buf_array`

## Requirements
- R1: After reset no request is raised, busy is 0, and a load to any buffer reports acc_miss=1 with rd_vld=0, one cycle after the access.
- R2: A normal allocate (alloc_wfirst=0) in IDLE raises fill_req with fill_tag_only=0 and shows the allocated line, way and page on req_line/req_way/req_ppn. A load to that buffer misses until fill_ack. On fill_ack, fill_data is copied in, with line byte b at fill_data[8b+7:8b]. The write mask is cleared, and fetched and line-valid are set.
- R3: A store writes only the bytes enabled in acc_be. Word w covers line bytes 4w..4w+3, and acc_be[k] / acc_wdata[8k+7:8k] is byte 4w+k. A load returns the merged word on rd_data one cycle later, with rd_vld=1.
- R4: Every store sets the mask bits of the bytes it writes. A buffer is dirty exactly when at least one mask bit is set. wb_mask bit b stands for line byte b.
- R5: Releasing a dirty, line-valid buffer raises wb_req with req_line and req_way of that buffer, wb_mask equal to the written bytes, and wb_data holding the buffer contents. After wb_ack the buffer is invalid and loads to it miss.
- R6: Releasing a clean buffer raises no request. The buffer is invalid on the next cycle.
- R7: An eviction notice whose line and way match a buffer clears that buffer's line-valid flag, so later loads to it miss. Buffers with a different way are not affected.
- R8: A write-first allocate with alloc_contig=0 raises no request. The buffer is immediately line-valid but not fetched.
- R9: A write-first allocate with alloc_contig=1 raises fill_req with fill_tag_only=1. The data arriving with its fill_ack is discarded, and the buffer stays not fetched.
- R10: Releasing a dirty contiguous write-first buffer that is not fetched and whose mask is not all ones first raises lower_req. wb_req follows only after lower_ack. If the mask is all ones, wb_req is raised directly with no lower_req.
- R11: A load from a line-valid buffer that is not fetched, where any enabled byte has its mask bit clear, sets rd_err one cycle later. A load from a fetched buffer, or from written bytes only, leaves rd_err at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Allocate command (accepted only while busy=0) |
| alloc_idx | input | 2 | Buffer to allocate |
| alloc_line | input | 10 | Cache line number of the buffer |
| alloc_way | input | 2 | Cache way of the line |
| alloc_ppn | input | 20 | Physical page number of the line |
| alloc_wfirst | input | 1 | Write-first allocate: skip the data fill |
| alloc_contig | input | 1 | With alloc_wfirst: whole line will be overwritten, tag-only allocation below |
| rel_vld | input | 1 | Release command (accepted only while busy=0, allocate has priority) |
| rel_idx | input | 2 | Buffer to release |
| busy | output | 1 | Sequencer is not in IDLE |
| acc_vld | input | 1 | Pipeline access valid |
| acc_wr | input | 1 | 1 = store, 0 = load |
| acc_idx | input | 2 | Buffer accessed |
| acc_word | input | 3 | Word within the line |
| acc_be | input | 4 | Byte enables within the word |
| acc_wdata | input | 32 | Store data |
| rd_vld | output | 1 | Load hit result valid (one cycle after the access) |
| rd_data | output | 32 | Load data |
| rd_err | output | 1 | Load read a never-written byte of an unfetched line |
| acc_miss | output | 1 | Access hit a buffer that is not line-valid |
| evict_vld | input | 1 | Cache eviction notice |
| evict_line | input | 10 | Evicted line number |
| evict_way | input | 2 | Evicted way |
| req_line | output | 10 | Line number for the current request |
| req_way | output | 2 | Way for the current request |
| req_ppn | output | 20 | Page number for the current request |
| fill_req | output | 1 | Fill or tag-only allocation request |
| fill_tag_only | output | 1 | Request is a tag-only allocation |
| fill_ack | input | 1 | Fill acknowledge, with data |
| fill_data | input | 256 | Fill line data |
| lower_req | output | 1 | Fetch the line from the level below the cache |
| lower_ack | input | 1 | Lower-level fetch done |
| wb_req | output | 1 | Masked writeback request |
| wb_ack | input | 1 | Writeback accepted |
| wb_mask | output | 32 | Byte mask of the writeback |
| wb_data | output | 256 | Writeback line data |

## Verification
The hardest state to reach is a contiguous write-first buffer that is still unfetched and only partly written at release, because only this state sends the sequencer through LOWER. The bench gets there by allocating with both write-first flags set and acknowledging the tag-only request with a recognisable data pattern. It then confirms, through rd_err on an unwritten word, that the pattern was discarded. Next it stores a single word and releases the buffer. It watches lower_req come up alone, and wb_req appear with a one-word mask only after lower_ack. A fully written contiguous buffer is released afterwards, to show that the direct path to WB is taken instead.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_LOWER,
        ST_WB
    } lb_state_e;
endpackage

// File: rtl/lbuf_entry.sv
module lbuf_entry #(
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 4,
    parameter int LN_W       = 10,
    parameter int WAY_W      = 2,
    parameter int PPN_W      = 20,
    localparam int WORDS     = LINE_BYTES / WORD_BYTES,
    localparam int WOFF_W    = $clog2(WORDS),
    localparam int WORD_BITS = WORD_BYTES * 8,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_en,
    input  logic                  alloc_wfirst,
    input  logic                  alloc_contig,
    input  logic [LN_W-1:0]       alloc_line,
    input  logic [WAY_W-1:0]      alloc_way,
    input  logic [PPN_W-1:0]      alloc_ppn,
    input  logic                  st_en,
    input  logic [WOFF_W-1:0]     st_word,
    input  logic [WORD_BYTES-1:0] st_be,
    input  logic [WORD_BITS-1:0]  st_wdata,
    input  logic                  fill_en,
    input  logic [LINE_BITS-1:0]  fill_data,
    input  logic                  evict_vld,
    input  logic [LN_W-1:0]       evict_line,
    input  logic [WAY_W-1:0]      evict_way,
    input  logic                  clr_en,
    output logic                  lvalid,
    output logic                  fetched,
    output logic                  dirty,
    output logic                  contig,
    output logic [LN_W-1:0]       line,
    output logic [WAY_W-1:0]      way,
    output logic [PPN_W-1:0]      ppn,
    output logic [LINE_BYTES-1:0] mask,
    output logic [LINE_BITS-1:0]  data
);
    logic [LINE_BYTES-1:0] st_mask;
    logic [LINE_BITS-1:0]  st_wide;
    logic                  evict_hit;

    // place the word's enables and data at their position in the line
    assign st_mask   = {{(LINE_BYTES-WORD_BYTES){1'b0}}, st_be} << (st_word * WORD_BYTES);
    assign st_wide   = {{(LINE_BITS-WORD_BITS){1'b0}}, st_wdata} << (st_word * WORD_BITS);
    assign evict_hit = evict_vld && (evict_line == line) && (evict_way == way);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else begin
            for (int b = 0; b < LINE_BYTES; b++) begin
                if (fill_en)
                    data[b*8 +: 8] <= fill_data[b*8 +: 8];
                else if (st_en && st_mask[b])
                    data[b*8 +: 8] <= st_wide[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvalid  <= 1'b0;
            fetched <= 1'b0;
            dirty   <= 1'b0;
            contig  <= 1'b0;
            line    <= '0;
            way     <= '0;
            ppn     <= '0;
            mask    <= '0;
        end else if (clr_en) begin
            lvalid  <= 1'b0;
            fetched <= 1'b0;
            dirty   <= 1'b0;
            contig  <= 1'b0;
            mask    <= '0;
        end else if (alloc_en) begin
            line    <= alloc_line;
            way     <= alloc_way;
            ppn     <= alloc_ppn;
            lvalid  <= alloc_wfirst;
            fetched <= 1'b0;
            dirty   <= 1'b0;
            contig  <= alloc_wfirst & alloc_contig;
            mask    <= '0;
        end else begin
            if (fill_en) begin
                fetched <= 1'b1;
                lvalid  <= 1'b1;
                mask    <= '0;
                dirty   <= 1'b0;
            end else if (st_en && (|st_be)) begin
                mask  <= mask | st_mask;
                dirty <= 1'b1;
            end
            if (evict_hit)
                lvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl
    import lbuf_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_vld,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             alloc_wfirst,
    input  logic             alloc_contig,
    input  logic             rel_vld,
    input  logic [IDX_W-1:0] rel_idx,
    input  logic             sel_dirty,
    input  logic             sel_lvalid,
    input  logic             sel_fetched,
    input  logic             sel_contig,
    input  logic             sel_full,
    input  logic             fill_ack,
    input  logic             lower_ack,
    input  logic             wb_ack,
    output logic             busy,
    output logic             fill_req,
    output logic             fill_tag_only,
    output logic             lower_req,
    output logic             wb_req,
    output logic             alloc_go,
    output logic             fill_go,
    output logic             clr_go,
    output logic [IDX_W-1:0] view_idx
);
    lb_state_e        state_q, state_d;
    logic [IDX_W-1:0] cur_q;
    logic             tag_only_q;
    logic             wb_needed, need_lower;

    assign view_idx   = (state_q == ST_IDLE) ? rel_idx : cur_q;
    assign wb_needed  = sel_dirty & sel_lvalid;
    assign need_lower = sel_contig & ~sel_fetched & ~sel_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cur_q      <= '0;
            tag_only_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                if (alloc_vld) begin
                    cur_q      <= alloc_idx;
                    tag_only_q <= alloc_wfirst & alloc_contig;
                end else if (rel_vld) begin
                    cur_q <= rel_idx;
                end
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (alloc_vld) begin
                    if (!alloc_wfirst || alloc_contig)
                        state_d = ST_FILL;
                end else if (rel_vld && wb_needed) begin
                    state_d = need_lower ? ST_LOWER : ST_WB;
                end
            end
            ST_FILL:  if (fill_ack)  state_d = ST_IDLE;
            ST_LOWER: if (lower_ack) state_d = ST_WB;
            ST_WB:    if (wb_ack)    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy          = (state_q != ST_IDLE);
        fill_req      = 1'b0;
        fill_tag_only = 1'b0;
        lower_req     = 1'b0;
        wb_req        = 1'b0;
        alloc_go      = 1'b0;
        fill_go       = 1'b0;
        clr_go        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                alloc_go = alloc_vld;
                clr_go   = ~alloc_vld & rel_vld & ~wb_needed;
            end
            ST_FILL: begin
                fill_req      = 1'b1;
                fill_tag_only = tag_only_q;
                fill_go       = fill_ack & ~tag_only_q;
            end
            ST_LOWER: lower_req = 1'b1;
            ST_WB: begin
                wb_req = 1'b1;
                clr_go = wb_ack;
            end
        endcase
    end
endmodule

// File: rtl/line_buf_array.sv
module line_buf_array #(
    parameter int NBUF       = 4,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 4,
    parameter int LN_W       = 10,
    parameter int WAY_W      = 2,
    parameter int PPN_W      = 20,
    localparam int IDX_W     = $clog2(NBUF),
    localparam int WORDS     = LINE_BYTES / WORD_BYTES,
    localparam int WOFF_W    = $clog2(WORDS),
    localparam int WORD_BITS = WORD_BYTES * 8,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_vld,
    input  logic [IDX_W-1:0]      alloc_idx,
    input  logic [LN_W-1:0]       alloc_line,
    input  logic [WAY_W-1:0]      alloc_way,
    input  logic [PPN_W-1:0]      alloc_ppn,
    input  logic                  alloc_wfirst,
    input  logic                  alloc_contig,
    input  logic                  rel_vld,
    input  logic [IDX_W-1:0]      rel_idx,
    output logic                  busy,
    input  logic                  acc_vld,
    input  logic                  acc_wr,
    input  logic [IDX_W-1:0]      acc_idx,
    input  logic [WOFF_W-1:0]     acc_word,
    input  logic [WORD_BYTES-1:0] acc_be,
    input  logic [WORD_BITS-1:0]  acc_wdata,
    output logic                  rd_vld,
    output logic [WORD_BITS-1:0]  rd_data,
    output logic                  rd_err,
    output logic                  acc_miss,
    input  logic                  evict_vld,
    input  logic [LN_W-1:0]       evict_line,
    input  logic [WAY_W-1:0]      evict_way,
    output logic [LN_W-1:0]       req_line,
    output logic [WAY_W-1:0]      req_way,
    output logic [PPN_W-1:0]      req_ppn,
    output logic                  fill_req,
    output logic                  fill_tag_only,
    input  logic                  fill_ack,
    input  logic [LINE_BITS-1:0]  fill_data,
    output logic                  lower_req,
    input  logic                  lower_ack,
    output logic                  wb_req,
    input  logic                  wb_ack,
    output logic [LINE_BYTES-1:0] wb_mask,
    output logic [LINE_BITS-1:0]  wb_data
);
    logic [NBUF-1:0]       ent_lvalid, ent_fetched, ent_dirty, ent_contig;
    logic [LN_W-1:0]       ent_line [NBUF];
    logic [WAY_W-1:0]      ent_way  [NBUF];
    logic [PPN_W-1:0]      ent_ppn  [NBUF];
    logic [LINE_BYTES-1:0] ent_mask [NBUF];
    logic [LINE_BITS-1:0]  ent_data [NBUF];
    logic                  alloc_go, fill_go, clr_go;
    logic [IDX_W-1:0]      view_idx;
    logic                  acc_hit, err_c;
    logic [WORD_BYTES-1:0] word_mask;

    lbuf_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_vld    (alloc_vld),
        .alloc_idx    (alloc_idx),
        .alloc_wfirst (alloc_wfirst),
        .alloc_contig (alloc_contig),
        .rel_vld      (rel_vld),
        .rel_idx      (rel_idx),
        .sel_dirty    (ent_dirty[view_idx]),
        .sel_lvalid   (ent_lvalid[view_idx]),
        .sel_fetched  (ent_fetched[view_idx]),
        .sel_contig   (ent_contig[view_idx]),
        .sel_full     (&ent_mask[view_idx]),
        .fill_ack     (fill_ack),
        .lower_ack    (lower_ack),
        .wb_ack       (wb_ack),
        .busy         (busy),
        .fill_req     (fill_req),
        .fill_tag_only(fill_tag_only),
        .lower_req    (lower_req),
        .wb_req       (wb_req),
        .alloc_go     (alloc_go),
        .fill_go      (fill_go),
        .clr_go       (clr_go),
        .view_idx     (view_idx)
    );

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        lbuf_entry #(
            .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES),
            .LN_W(LN_W), .WAY_W(WAY_W), .PPN_W(PPN_W)
        ) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_en    (alloc_go && (alloc_idx == IDX_W'(i))),
            .alloc_wfirst(alloc_wfirst),
            .alloc_contig(alloc_contig),
            .alloc_line  (alloc_line),
            .alloc_way   (alloc_way),
            .alloc_ppn   (alloc_ppn),
            .st_en       (acc_vld && acc_wr && ent_lvalid[i] && (acc_idx == IDX_W'(i))),
            .st_word     (acc_word),
            .st_be       (acc_be),
            .st_wdata    (acc_wdata),
            .fill_en     (fill_go && (view_idx == IDX_W'(i))),
            .fill_data   (fill_data),
            .evict_vld   (evict_vld),
            .evict_line  (evict_line),
            .evict_way   (evict_way),
            .clr_en      (clr_go && (view_idx == IDX_W'(i))),
            .lvalid      (ent_lvalid[i]),
            .fetched     (ent_fetched[i]),
            .dirty       (ent_dirty[i]),
            .contig      (ent_contig[i]),
            .line        (ent_line[i]),
            .way         (ent_way[i]),
            .ppn         (ent_ppn[i]),
            .mask        (ent_mask[i]),
            .data        (ent_data[i])
        );
    end

    assign req_line = ent_line[view_idx];
    assign req_way  = ent_way[view_idx];
    assign req_ppn  = ent_ppn[view_idx];
    assign wb_mask  = ent_mask[view_idx];
    assign wb_data  = ent_data[view_idx];

    assign acc_hit   = acc_vld & ent_lvalid[acc_idx];
    assign word_mask = ent_mask[acc_idx][acc_word*WORD_BYTES +: WORD_BYTES];
    assign err_c     = acc_hit & ~acc_wr & ~ent_fetched[acc_idx] & (|(acc_be & ~word_mask));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld   <= 1'b0;
            rd_data  <= '0;
            rd_err   <= 1'b0;
            acc_miss <= 1'b0;
        end else begin
            rd_vld   <= acc_hit & ~acc_wr;
            rd_data  <= ent_data[acc_idx][acc_word*WORD_BITS +: WORD_BITS];
            rd_err   <= err_c;
            acc_miss <= acc_vld & ~ent_lvalid[acc_idx];
        end
    end
endmodule

// File: rtl/line_buf_array_chk.sv
module line_buf_array_chk #(
    parameter int LINE_BYTES = 32,
    parameter int LN_W       = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fill_req,
    input logic                  fill_ack,
    input logic                  lower_req,
    input logic                  lower_ack,
    input logic                  wb_req,
    input logic                  wb_ack,
    input logic [LINE_BYTES-1:0] wb_mask,
    input logic [LN_W-1:0]       req_line,
    input logic                  acc_miss,
    input logic                  rd_vld,
    input logic                  rd_err
);
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_req, lower_req, wb_req})); // R5
    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && !fill_ack |=> fill_req); // R2
    AST_WB_MASK_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (wb_mask != '0)); // R4
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req && $stable(req_line)); // R5
    AST_LOWER_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
        lower_req && lower_ack |=> wb_req); // R10
    AST_MISS_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        acc_miss |-> !rd_vld); // R7
    AST_MISS_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        acc_miss |-> !rd_err); // R11
endmodule

bind line_buf_array line_buf_array_chk #(
    .LINE_BYTES(LINE_BYTES),
    .LN_W(LN_W)
) u_chk (.*);

// File: tb/test_line_buf_array.sv
module test_line_buf_array;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         alloc_vld = 0, alloc_wfirst = 0, alloc_contig = 0;
    logic [1:0]   alloc_idx = 0, alloc_way = 0;
    logic [9:0]   alloc_line = 0;
    logic [19:0]  alloc_ppn = 0;
    logic         rel_vld = 0;
    logic [1:0]   rel_idx = 0;
    logic         busy;
    logic         acc_vld = 0, acc_wr = 0;
    logic [1:0]   acc_idx = 0;
    logic [2:0]   acc_word = 0;
    logic [3:0]   acc_be = 0;
    logic [31:0]  acc_wdata = 0;
    logic         rd_vld, rd_err, acc_miss;
    logic [31:0]  rd_data;
    logic         evict_vld = 0;
    logic [9:0]   evict_line = 0;
    logic [1:0]   evict_way = 0;
    logic [9:0]   req_line;
    logic [1:0]   req_way;
    logic [19:0]  req_ppn;
    logic         fill_req, fill_tag_only, lower_req, wb_req;
    logic         fill_ack = 0, lower_ack = 0, wb_ack = 0;
    logic [255:0] fill_data = '0;
    logic [31:0]  wb_mask;
    logic [255:0] wb_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    line_buf_array i_line_buf_array (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] pat(input logic [7:0] s);
        for (int b = 0; b < 32; b++) pat[b*8 +: 8] = s + 8'(b);
    endfunction

    function automatic logic [31:0] pword(input logic [7:0] s, input int w);
        return pat(s)[w*32 +: 32];
    endfunction

    task automatic acc(input logic [1:0] idx, input logic wr, input logic [2:0] w,
                       input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        acc_vld = 1; acc_wr = wr; acc_idx = idx; acc_word = w; acc_be = be; acc_wdata = d;
        @(negedge clk);
        acc_vld = 0; acc_wr = 0;
    endtask

    task automatic alloc(input logic [1:0] idx, input logic [9:0] ln, input logic [1:0] wy,
                         input logic [19:0] pp, input logic wf, input logic ct);
        @(negedge clk);
        alloc_vld = 1; alloc_idx = idx; alloc_line = ln; alloc_way = wy; alloc_ppn = pp;
        alloc_wfirst = wf; alloc_contig = ct;
        @(negedge clk);
        alloc_vld = 0; alloc_wfirst = 0; alloc_contig = 0;
    endtask

    task automatic fill(input logic [255:0] d);
        @(negedge clk);
        fill_ack = 1; fill_data = d;
        @(negedge clk);
        fill_ack = 0;
    endtask

    task automatic release_buf(input logic [1:0] idx);
        @(negedge clk);
        rel_vld = 1; rel_idx = idx;
        @(negedge clk);
        rel_vld = 0;
    endtask

    task automatic ack_wb();
        @(negedge clk);
        wb_ack = 1;
        @(negedge clk);
        wb_ack = 0;
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 no request", {fill_req, lower_req, wb_req}, 0);
        acc(2'd0, 0, 3'd0, 4'hF, 0);
        chk("R1 miss", acc_miss, 1);
        chk("R1 rd_vld", rd_vld, 0);
    endtask

    task automatic t_fill_store_wb();
        alloc(2'd0, 10'h12, 2'd1, 20'hABCDE, 0, 0);
        chk("R2 fill_req", {fill_req, fill_tag_only}, 2'b10);
        chk("R2 req addr", {req_line, req_way, req_ppn}, {10'h12, 2'd1, 20'hABCDE});
        acc(2'd0, 0, 3'd3, 4'hF, 0);
        chk("R2 miss before fill", acc_miss, 1);
        fill(pat(8'h40));
        chk("R2 idle after ack", {busy, fill_req}, 0);
        acc(2'd0, 0, 3'd3, 4'hF, 0);
        chk("R2 fill data", {rd_vld, acc_miss, rd_data}, {2'b10, pword(8'h40, 3)});
        chk("R11 fetched no err", rd_err, 0);
        acc(2'd0, 1, 3'd3, 4'b0101, 32'hAABBCCDD);
        acc(2'd0, 1, 3'd7, 4'hF, 32'h11223344);
        acc(2'd0, 0, 3'd3, 4'hF, 0);
        chk("R3 merged word", rd_data, 32'h4FBB4DDD);
        release_buf(2'd0);
        chk("R5 wb_req", {wb_req, lower_req}, 2'b10);
        chk("R5 wb addr", {req_line, req_way}, {10'h12, 2'd1});
        chk("R4 wb_mask", wb_mask, 32'hF000_5000);
        chk("R5 wb word3", wb_data[3*32 +: 32], 32'h4FBB4DDD);
        chk("R5 wb word7", wb_data[7*32 +: 32], 32'h11223344);
        ack_wb();
        chk("R5 done", {busy, wb_req}, 0);
        acc(2'd0, 0, 3'd3, 4'hF, 0);
        chk("R5 freed", acc_miss, 1);
    endtask

    task automatic t_clean_release();
        alloc(2'd1, 10'h33, 2'd0, 20'h1, 0, 0);
        fill(pat(8'h80));
        release_buf(2'd1);
        chk("R6 no request", {busy, fill_req, lower_req, wb_req}, 0);
        acc(2'd1, 0, 3'd0, 4'hF, 0);
        chk("R6 freed", acc_miss, 1);
    endtask

    task automatic t_evict();
        alloc(2'd1, 10'h5, 2'd0, 20'h2, 0, 0);
        fill(pat(8'h10));
        alloc(2'd2, 10'h5, 2'd2, 20'h3, 0, 0);
        fill(pat(8'h20));
        @(negedge clk);
        evict_vld = 1; evict_line = 10'h5; evict_way = 2'd0;
        @(negedge clk);
        evict_vld = 0;
        acc(2'd1, 0, 3'd1, 4'hF, 0);
        chk("R7 evicted miss", {acc_miss, rd_vld}, 2'b10);
        acc(2'd2, 0, 3'd1, 4'hF, 0);
        chk("R7 other way kept", {acc_miss, rd_vld, rd_data}, {2'b01, pword(8'h20, 1)});
        release_buf(2'd2);
        release_buf(2'd1);
    endtask

    task automatic t_write_first();
        alloc(2'd2, 10'h44, 2'd3, 20'h4, 1, 0);
        chk("R8 no fill", {busy, fill_req}, 0);
        acc(2'd2, 1, 3'd0, 4'hF, 32'hCAFEF00D);
        acc(2'd2, 0, 3'd0, 4'hF, 0);
        chk("R8 store read back", {rd_vld, rd_data}, {1'b1, 32'hCAFEF00D});
        chk("R11 written no err", rd_err, 0);
        acc(2'd2, 0, 3'd1, 4'h1, 0);
        chk("R11 unwritten err", rd_err, 1);
        release_buf(2'd2);
        chk("R8 wb direct", {lower_req, wb_req, wb_mask}, {2'b01, 32'h0000_000F});
        ack_wb();
    endtask

    task automatic t_contig_partial();
        alloc(2'd3, 10'h77, 2'd2, 20'h5, 1, 1);
        chk("R9 tag-only req", {fill_req, fill_tag_only}, 2'b11);
        fill(pat(8'hC0));
        chk("R9 idle", busy, 0);
        acc(2'd3, 0, 3'd2, 4'hF, 0);
        chk("R9 data discarded", {rd_vld, rd_err}, 2'b11);
        acc(2'd3, 1, 3'd0, 4'hF, 32'h12345678);
        release_buf(2'd3);
        chk("R10 lower first", {lower_req, wb_req}, 2'b10);
        @(negedge clk);
        chk("R10 lower held", {lower_req, wb_req}, 2'b10);
        lower_ack = 1;
        @(negedge clk);
        lower_ack = 0;
        chk("R10 wb after lower", {lower_req, wb_req, wb_mask}, {2'b01, 32'h0000_000F});
        ack_wb();
    endtask

    task automatic t_contig_full();
        alloc(2'd3, 10'h78, 2'd1, 20'h6, 1, 1);
        fill('0);
        for (int w = 0; w < 8; w++) acc(2'd3, 1, 3'(w), 4'hF, 32'(w));
        release_buf(2'd3);
        chk("R10 full direct wb", {lower_req, wb_req, wb_mask}, {2'b01, 32'hFFFF_FFFF});
        chk("R4 full data", wb_data[5*32 +: 32], 32'd5);
        ack_wb();
        chk("R10 idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fill_store_wb();
        t_clean_release();
        t_evict();
        t_write_first();
        t_contig_partial();
        t_contig_full();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule